// File: doc/BRIEF.md
# Match-Driven Timer with Single-Edge PWM Outputs

This block is an up-counter that advances once per prescale tick while it is enabled. Each of its four channels holds a compare value and drives one output pin. Software picks the mode of each pin on its own. In external-match mode, a 2-bit action field decides what a compare hit does to the pin: nothing, clear, set or toggle. In PWM mode, the pin rises when the count hits the channel's compare value and falls when the counter is reloaded to zero.

Any channel can be marked as a reload channel. When the count equals that channel's compare value on a tick, the next count is zero instead of value+1, so the compare value sets the period. Channel 3 is the natural period channel, which leaves channels 0 to 2 free for up to three PWM waveforms. All configuration arrives through a small write-only register port. A write takes effect on the cycle after it is presented.

Top module: `mtpwm_top`

## Requirements
- R1: After reset the count is 0, every output is 0, the timer is disabled, every channel is in external-match mode with action 00, no channel is a reload channel, and every compare value is 0. Enabling the timer with these defaults leaves every output at 0.
- R2: On each clock edge where tick_i is 1 and the timer is enabled, the count grows by one. Without a tick, or while the timer is disabled, the count holds.
- R3: If, on a counting tick, the count equals the compare value of any channel whose reload bit is set, the count becomes 0 on that edge. A compare value V therefore gives a period of V+1 ticks.
- R4: In external-match mode, channel i's action field sits at bits [2i+1:2i] of the action register. On a counting tick where the count equals the channel's compare value, the field applies: 00 leaves the output, 01 drives it to 0, 10 drives it to 1, and 11 inverts it. A reload does not affect external-match outputs.
- R5: An output never changes on a cycle without a counting tick, even while the count sits on its compare value, and it does not change while the timer is disabled.
- R6: In PWM mode, an output goes to 1 on the counting tick where the count equals its compare value.
- R7: In PWM mode, an output goes to 0 on the tick that reloads the counter. If that same tick is also the channel's own compare hit, the clear wins, so a compare value equal to the period value keeps the output low.
- R8: In PWM mode, a compare value of 0 raises the output on the first tick of every period, the tick taken at count 0.
- R9: In PWM mode, a compare value above the reload value is never reached, and the output stays 0.
- R10: Changing a channel's mode does not change its output. The level holds until the next compare hit or reload acts on it under the new mode.
- R11: Register map on wr_addr_i: addresses 0 to 3 hold the compare values of channels 0 to 3; address 4 bit 0 is the timer enable; address 5 bits [3:0] are the per-channel PWM-mode bits; address 6 bits [3:0] are the per-channel reload bits; address 7 bits [7:0] are the action fields. A write is in force from the following clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Prescale tick, one counting step per cycle it is high |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | CNT_W | Register write data |
| count_o | output | CNT_W | Current counter value |
| match_o | output | 4 | Channel output pins |

## Verification
The count and all four pins are registered. They change on the same rising edge that samples a tick, one edge after the count reached the value being compared. A register write is in force one cycle later. The bench raises a tick for exactly one cycle from a falling edge and samples at the next falling edge. Every expected count and pin level is read after the edge that produced it and before the next tick. Hold and ignore cases are sampled after several tick-free cycles, so any change that leaked out would be visible.

// File: rtl/mtpwm_pkg.sv
package mtpwm_pkg;
    // Channel count is fixed by the register map; the counter width is a parameter.
    localparam int NUM_CH = 4;
    localparam int ADDR_W = 3;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_CLEAR  = 2'b01,
        ACT_SET    = 2'b10,
        ACT_TOGGLE = 2'b11
    } match_act_e;

    localparam logic [ADDR_W-1:0] ADR_CTRL   = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_PWM    = 3'd5;
    localparam logic [ADDR_W-1:0] ADR_RELOAD = 3'd6;
    localparam logic [ADDR_W-1:0] ADR_ACTION = 3'd7;
endpackage

// File: rtl/mtpwm_cfg.sv
module mtpwm_cfg
    import mtpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en_i,
    input  logic [ADDR_W-1:0]                wr_addr_i,
    input  logic [CNT_W-1:0]                 wr_data_i,
    output logic [NUM_CH-1:0][CNT_W-1:0]     cmp_val_o,
    output logic                             run_o,
    output logic [NUM_CH-1:0]                pwm_mode_o,
    output logic [NUM_CH-1:0]                reload_sel_o,
    output logic [NUM_CH-1:0][1:0]           action_o
);
    localparam int ACT_BITS = 2 * NUM_CH;

    typedef struct packed {
        logic [NUM_CH-1:0][CNT_W-1:0] cmp;
        logic                         run;
        logic [NUM_CH-1:0]            pwm;
        logic [NUM_CH-1:0]            rsel;
        logic [NUM_CH-1:0][1:0]       act;
    } cfg_t;

    cfg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (wr_addr_i == ADDR_W'(c)) begin
                    st_d.cmp[c] = wr_data_i;
                end
            end
            case (wr_addr_i)
                ADR_CTRL:   st_d.run  = wr_data_i[0];
                ADR_PWM:    st_d.pwm  = wr_data_i[NUM_CH-1:0];
                ADR_RELOAD: st_d.rsel = wr_data_i[NUM_CH-1:0];
                ADR_ACTION: st_d.act  = wr_data_i[ACT_BITS-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmp_val_o    = st_q.cmp;
    assign run_o        = st_q.run;
    assign pwm_mode_o   = st_q.pwm;
    assign reload_sel_o = st_q.rsel;
    assign action_o     = st_q.act;

    // A cycle without a write leaves the configuration untouched.
    p_cfg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(st_q));
endmodule

// File: rtl/mtpwm_count.sv
module mtpwm_count
    import mtpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         tick_i,
    input  logic                         run_i,
    input  logic [NUM_CH-1:0][CNT_W-1:0] cmp_val_i,
    input  logic [NUM_CH-1:0]            reload_sel_i,
    output logic [CNT_W-1:0]             count_o,
    output logic [NUM_CH-1:0]            hit_o,
    output logic                         reload_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_t;

    ctr_t st_d, st_q;
    logic [NUM_CH-1:0] equal;
    logic              step;

    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            equal[c] = (st_q.cnt == cmp_val_i[c]);
        end
        step     = tick_i && run_i;
        hit_o    = step ? equal : '0;
        reload_o = step && |(equal & reload_sel_i);

        st_d = st_q;
        if (reload_o) begin
            st_d.cnt = '0;
        end else if (step) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.cnt;

    p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick_i && run_i) |=> $stable(st_q.cnt));

    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && run_i && !reload_o) |=> (st_q.cnt == CNT_W'($past(st_q.cnt) + 1'b1)));

    p_reload_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reload_o |=> (st_q.cnt == '0));

    p_hit_only_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick_i && run_i) |-> (hit_o == '0) && !reload_o);
endmodule

// File: rtl/mtpwm_chan.sv
module mtpwm_chan
    import mtpwm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit_i,
    input  logic       reload_i,
    input  logic       pwm_i,
    input  logic [1:0] action_i,
    output logic       pin_o
);
    typedef struct packed {
        logic lvl;
    } chan_t;

    chan_t      st_d, st_q;
    match_act_e act;

    always_comb begin
        act  = match_act_e'(action_i);
        st_d = st_q;
        if (pwm_i) begin
            // Clear at reload takes priority over a set on the same tick.
            if (reload_i) begin
                st_d.lvl = 1'b0;
            end else if (hit_i) begin
                st_d.lvl = 1'b1;
            end
        end else if (hit_i) begin
            case (act)
                ACT_CLEAR:  st_d.lvl = 1'b0;
                ACT_SET:    st_d.lvl = 1'b1;
                ACT_TOGGLE: st_d.lvl = ~st_q.lvl;
                default:    st_d.lvl = st_q.lvl;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_o = st_q.lvl;

    p_pwm_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_i && hit_i && !reload_i) |=> st_q.lvl);

    p_pwm_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_i && reload_i) |=> !st_q.lvl);

    p_quiet_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_i && !(pwm_i && reload_i)) |=> $stable(st_q.lvl));

    p_toggle_flips_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm_i && hit_i && action_i == 2'b11) |=> (st_q.lvl != $past(st_q.lvl)));

    p_none_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm_i && hit_i && action_i == 2'b00) |=> $stable(st_q.lvl));
endmodule

// File: rtl/mtpwm_top.sv
module mtpwm_top
    import mtpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [2:0]        wr_addr_i,
    input  logic [CNT_W-1:0]  wr_data_i,
    output logic [CNT_W-1:0]  count_o,
    output logic [3:0]        match_o
);
    logic [NUM_CH-1:0][CNT_W-1:0] cmp_val;
    logic                         run;
    logic [NUM_CH-1:0]            pwm_mode;
    logic [NUM_CH-1:0]            reload_sel;
    logic [NUM_CH-1:0][1:0]       action;
    logic [NUM_CH-1:0]            hit;
    logic                         reload;

    mtpwm_cfg #(.CNT_W(CNT_W)) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en_i      (wr_en_i),
        .wr_addr_i    (wr_addr_i),
        .wr_data_i    (wr_data_i),
        .cmp_val_o    (cmp_val),
        .run_o        (run),
        .pwm_mode_o   (pwm_mode),
        .reload_sel_o (reload_sel),
        .action_o     (action)
    );

    mtpwm_count #(.CNT_W(CNT_W)) u_count (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_i),
        .run_i        (run),
        .cmp_val_i    (cmp_val),
        .reload_sel_i (reload_sel),
        .count_o      (count_o),
        .hit_o        (hit),
        .reload_o     (reload)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        mtpwm_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .hit_i    (hit[c]),
            .reload_i (reload),
            .pwm_i    (pwm_mode[c]),
            .action_i (action[c]),
            .pin_o    (match_o[c])
        );
    end

    // Pins stay low for the first cycle after reset.
    p_reset_low_r1: assert property (@(posedge clk)
        !rst_n |=> (match_o == '0) && (count_o == '0));
endmodule

// File: tb/mtpwm_top_test.sv
module mtpwm_top_test;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick_i = 1'b0;
    logic             wr_en_i = 1'b0;
    logic [2:0]       wr_addr_i = '0;
    logic [CNT_W-1:0] wr_data_i = '0;
    logic [CNT_W-1:0] count_o;
    logic [3:0]       match_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    mtpwm_top #(.CNT_W(CNT_W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .count_o   (count_o),
        .match_o   (match_o)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        tick_i = 1'b0;
        wr_en_i = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [CNT_W-1:0] d);
        @(negedge clk);
        wr_en_i = 1'b1;
        wr_addr_i = a;
        wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_i = 1'b1;
            @(negedge clk);
            tick_i = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset_state();
        do_reset();
        idle(1);
        check("R1 count after reset", count_o, 0);
        check("R1 pins after reset", match_o, 0);
        wr(3'd4, 16'd1);
        ticks(3);
        check("R1 default config counts freely", count_o, 3);
        check("R1 default action leaves pins low", match_o, 0);
    endtask

    task automatic t_counting();
        do_reset();
        wr(3'd4, 16'd1);
        ticks(1);
        check("R11 enable write in force next cycle", count_o, 1);
        ticks(4);
        check("R2 count after five ticks", count_o, 5);
        idle(6);
        check("R2 count holds without tick", count_o, 5);
        wr(3'd4, 16'd0);
        ticks(3);
        check("R2 count holds while disabled", count_o, 5);
    endtask

    task automatic t_reload();
        do_reset();
        wr(3'd3, 16'd4);
        wr(3'd6, 16'h8);
        wr(3'd4, 16'd1);
        ticks(4);
        check("R3 count reaches period value", count_o, 4);
        ticks(1);
        check("R3 reload to zero", count_o, 0);
        ticks(5);
        check("R3 period of five ticks", count_o, 0);
        wr(3'd1, 16'd2);
        wr(3'd6, 16'hA);
        ticks(3);
        check("R3 lower reload channel wins first", count_o, 0);
    endtask

    task automatic t_actions();
        do_reset();
        wr(3'd3, 16'd3);
        wr(3'd6, 16'h8);
        wr(3'd0, 16'd1);
        wr(3'd1, 16'd1);
        wr(3'd2, 16'd0);
        wr(3'd7, 16'h2B);
        wr(3'd4, 16'd1);
        ticks(1);
        check("R4 set at compare 0", match_o, 4'b0100);
        ticks(1);
        check("R4 toggle and set at compare 1", match_o, 4'b0111);
        ticks(2);
        check("R4 reload count", count_o, 0);
        check("R4 reload leaves external pins", match_o, 4'b0111);
        ticks(2);
        check("R4 second toggle returns low", match_o, 4'b0110);
        wr(3'd7, 16'h1B);
        ticks(3);
        check("R4 clear action", match_o, 4'b0010);
    endtask

    task automatic t_hold();
        do_reset();
        wr(3'd0, 16'd1);
        wr(3'd7, 16'h3);
        wr(3'd4, 16'd1);
        ticks(1);
        idle(10);
        check("R5 no toggle while parked on compare", match_o, 0);
        ticks(1);
        check("R5 toggle on the tick", match_o, 1);
        wr(3'd4, 16'd0);
        wr(3'd0, 16'd2);
        ticks(3);
        check("R5 disabled timer keeps pin", match_o, 1);
        check("R5 disabled timer keeps count", count_o, 2);
    endtask

    task automatic t_pwm();
        do_reset();
        wr(3'd3, 16'd4);
        wr(3'd6, 16'h8);
        wr(3'd0, 16'd2);
        wr(3'd1, 16'd4);
        wr(3'd5, 16'h3);
        wr(3'd4, 16'd1);
        ticks(2);
        check("R6 low before compare", match_o, 0);
        ticks(1);
        check("R6 high after compare", match_o, 1);
        ticks(1);
        check("R6 stays high", match_o, 1);
        ticks(1);
        check("R7 cleared on reload", match_o, 0);
        check("R7 compare equal to period stays low", match_o[1], 0);
        ticks(3);
        check("R6 high again next period", match_o, 1);
    endtask

    task automatic t_edges();
        do_reset();
        wr(3'd3, 16'd3);
        wr(3'd6, 16'h8);
        wr(3'd0, 16'd0);
        wr(3'd1, 16'd7);
        wr(3'd5, 16'h3);
        wr(3'd4, 16'd1);
        ticks(1);
        check("R8 compare zero rises on first tick", match_o, 1);
        ticks(3);
        check("R8 cleared at reload", match_o, 0);
        ticks(1);
        check("R8 rises again at count zero", match_o, 1);
        ticks(6);
        check("R9 compare above period stays low", match_o[1], 0);
    endtask

    task automatic t_mode_switch();
        do_reset();
        wr(3'd3, 16'd3);
        wr(3'd6, 16'h8);
        wr(3'd1, 16'd1);
        wr(3'd7, 16'h8);
        wr(3'd4, 16'd1);
        ticks(2);
        check("R10 external set", match_o, 4'b0010);
        wr(3'd5, 16'h2);
        idle(3);
        check("R10 level kept after switch to PWM", match_o, 4'b0010);
        ticks(2);
        check("R10 PWM reload clears kept level", match_o, 0);
        ticks(2);
        check("R10 PWM rise", match_o, 4'b0010);
        wr(3'd5, 16'h0);
        wr(3'd7, 16'h0);
        idle(2);
        check("R10 level kept after switch to external", match_o, 4'b0010);
        ticks(2);
        check("R10 external pin survives reload", match_o, 4'b0010);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_counting();
        t_reload();
        t_actions();
        t_hold();
        t_pwm();
        t_edges();
        t_mode_switch();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule